// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects the interrupt events of a network controller into one 16-bit status register. Each status bit is set by a single-cycle pulse from the receive, transmit, bus, statistics or link logic. The bit stays set until software writes a one to it. A 16-bit enable register chooses which status bits may drive the single level-sensitive interrupt line. Two fixed groupings of the status bits produce a "normal" summary and an "abnormal" summary. Software uses these to decide quickly which handler paths to run.

The block also holds two 16-bit error counters, one for missed frames and one for frames with CRC errors. Reading a counter returns its value and clears it. Before a counter can overflow, it raises the statistics event in status bit 7, so software can drain it in time. All access goes through a plain register read/write port with byte offsets. Read data is registered. There is no streaming data path, so no valid/ready handshake and no back-pressure is needed: every access completes in one cycle.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status register, the enable register, both error counters, `reg_rdata`, `irq`, `normal_sum` and `abnormal_sum` are all zero.
- R2: A high level on `ev_pulse[i]` during a clock edge sets status bit i at that edge. The bit then stays set until software clears it. Bit 0 is receive done, bit 1 transmit done, bit 5 receive ring empty, bit 8 early receive and bit 15 wake-up.
- R3: A write to offset 0x0C clears every status bit whose write-data bit is 1 and leaves the other bits unchanged. If an event pulse and a clear reach the same bit in the same cycle, the bit stays set.
- R4: The enable register at offset 0x0E is written and read as a whole 16-bit word. `irq` is high exactly while (status AND enable) is non-zero, so an enable of 0x0000 holds `irq` low whatever the status holds.
- R5: `normal_sum` is high while any status bit in mask 0x0003 is set. `abnormal_sum` is high while any status bit in mask 0xC260 is set. Neither summary depends on the enable register.
- R6: A read strobe at offset 0x0C, 0x0E, 0x7C (missed-frame counter) or 0x7E (CRC-error counter) puts the addressed value on `reg_rdata` one cycle later. Any other offset reads 0, and `reg_rdata` is 0 in any cycle that follows a cycle without a read strobe.
- R7: Each cycle with `miss_inc` (or `crc_inc`) high adds one to the missed-frame (or CRC-error) counter. A counter that reaches 0xFFFF stops there.
- R8: Reading a counter returns its value and clears it. If an increment arrives in the same cycle as the read, the counter becomes 1.
- R9: Writes to the counter offsets 0x7C and 0x7E have no effect.
- R10: When either counter steps onto the value 0xC000, status bit 7 (statistics near-maximum) is set. A counter that already holds 0xC000 or more, or that passes that value again without first stepping onto it, does not set the bit again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after the read strobe |
| ev_pulse | input | 16 | Event pulses, one per status bit |
| miss_inc | input | 1 | Missed-frame counter increment |
| crc_inc | input | 1 | CRC-error counter increment |
| irq | output | 1 | Level interrupt request |
| normal_sum | output | 1 | Normal-group summary |
| abnormal_sum | output | 1 | Abnormal-group summary |

## Verification
The bench targets a clear and an event that hit the same bit in the same cycle. A design that lets the clear win would lose that event, and the status would read back empty. It reads a counter while an increment arrives; a design that drops the increment reads back 0 instead of 1. It drives a counter to one step below 0xC000 and then onto it, and then one step past it. A design with an off-by-one threshold sets bit 7 one count early or late, and a design that compares by level sets bit 7 again after software clears it. It also writes to the read-only counter offsets and reads unmapped offsets. A decode fault there would show up as corrupted counts or stray read data.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h0E;
  localparam logic [ADDR_W-1:0] OFS_MISS   = 8'h7C;
  localparam logic [ADDR_W-1:0] OFS_CRC    = 8'h7E;

  localparam logic [REG_W-1:0] NORMAL_GROUP   = 16'h0003;
  localparam logic [REG_W-1:0] ABNORMAL_GROUP = 16'hC260;

  localparam int STATS_BIT = 7;
  localparam int N_CNT     = 2;   // index 0: missed frames, 1: CRC errors

  typedef struct packed {
    logic wr_status;
    logic wr_enable;
    logic rd_status;
    logic rd_enable;
    logic rd_miss;
    logic rd_crc;
  } reg_sel_t;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_ctl_pkg::*;
(
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel           = '0;
    sel.wr_status = wr_en && (addr == OFS_STATUS);
    sel.wr_enable = wr_en && (addr == OFS_ENABLE);
    sel.rd_status = rd_en && (addr == OFS_STATUS);
    sel.rd_enable = rd_en && (addr == OFS_ENABLE);
    sel.rd_miss   = rd_en && (addr == OFS_MISS);
    sel.rd_crc    = rd_en && (addr == OFS_CRC);
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic         en_wr,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] enable
);
  // One sticky flop per source; the event has priority over the clear.
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     bit_q <= 1'b0;
      else if (ev[b])                 bit_q <= 1'b1;
      else if (clr_en && clr_mask[b]) bit_q <= 1'b0;
    end
    assign status[b] = bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable <= '0;
    else if (en_wr) enable <= en_wdata;
  end

  // R2: any pulsed source is visible in the status after the edge
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((status & $past(ev)) == $past(ev)));

  // R3: a clear not met by an event leaves those bits low
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && ((clr_mask & ~ev) != '0)) |=> ((status & $past(clr_mask & ~ev)) == '0));

  // R3: bits outside the clear mask and without events keep their value
  assert_untouched_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0 && !clr_en) |=> $stable(status));
endmodule

// File: rtl/irq_err_counter.sv
module irq_err_counter #(
  parameter int W = 16,
  parameter logic [W-1:0] NEAR = 16'hC000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         rd_clr,
  output logic [W-1:0] count,
  output logic         near_ev
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] nxt;

  always_comb begin
    if (rd_clr)                     nxt = inc ? W'(1) : '0;
    else if (inc && count != TOP)   nxt = count + W'(1);
    else                            nxt = count;
    near_ev = (nxt == NEAR) && (count != NEAR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  // R8: a read without a coinciding increment empties the counter
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !inc) |=> (count == '0));

  // R7: no increment and no read means no change
  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !inc) |=> $stable(count));

  // R7: counting never wraps back below the saturated value
  assert_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !rd_clr) |=> (count == TOP));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int CNT_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [REG_W-1:0]  ev_pulse,
  input  logic              miss_inc,
  input  logic              crc_inc,
  output logic              irq,
  output logic              normal_sum,
  output logic              abnormal_sum
);
  localparam logic [CNT_W-1:0] NEAR_MAX = CNT_W'(3) << (CNT_W - 2);

  reg_sel_t         sel;
  logic [REG_W-1:0] status;
  logic [REG_W-1:0] enable;
  logic [REG_W-1:0] ev_all;
  logic [N_CNT-1:0] inc_v;
  logic [N_CNT-1:0] clr_v;
  logic [N_CNT-1:0] near_v;
  logic [CNT_W-1:0] cnt [N_CNT];

  irq_addr_decode i_dec (
    .wr_en (reg_wr_en),
    .rd_en (reg_rd_en),
    .addr  (reg_addr),
    .sel   (sel)
  );

  assign inc_v = {crc_inc, miss_inc};
  assign clr_v = {sel.rd_crc, sel.rd_miss};

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    irq_err_counter #(.W(CNT_W), .NEAR(NEAR_MAX)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc_v[k]),
      .rd_clr  (clr_v[k]),
      .count   (cnt[k]),
      .near_ev (near_v[k])
    );
  end

  always_comb begin
    ev_all            = ev_pulse;
    ev_all[STATS_BIT] = ev_pulse[STATS_BIT] | (|near_v);
  end

  irq_status_bank #(.W(REG_W)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_all),
    .clr_en   (sel.wr_status),
    .clr_mask (reg_wdata),
    .en_wr    (sel.wr_enable),
    .en_wdata (reg_wdata),
    .status   (status),
    .enable   (enable)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             reg_rdata <= '0;
    else if (sel.rd_status) reg_rdata <= status;
    else if (sel.rd_enable) reg_rdata <= enable;
    else if (sel.rd_miss)   reg_rdata <= REG_W'(cnt[0]);
    else if (sel.rd_crc)    reg_rdata <= REG_W'(cnt[1]);
    else                    reg_rdata <= '0;
  end

  assign irq          = |(status & enable);
  assign normal_sum   = |(status & NORMAL_GROUP);
  assign abnormal_sum = |(status & ABNORMAL_GROUP);

  // R4: a cleared mask keeps the line quiet
  assert_mask_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);

  // R5: the normal summary only rises after an event in its group
  assert_normal_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(normal_sum) |-> ($past(ev_all & NORMAL_GROUP) != '0));

  // R5: the abnormal summary only rises after an event in its group
  assert_abnormal_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abnormal_sum) |-> ($past(ev_all & ABNORMAL_GROUP) != '0));

  // R6: read data is zero after a cycle without a read strobe
  assert_rdata_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> (reg_rdata == '0));

  // R10: the statistics bit appears when a counter steps onto the threshold
  assert_near_sets_stats_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (near_v != '0) |=> status[STATS_BIT]);
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [15:0] ev_pulse = '0;
  logic        miss_inc = 1'b0, crc_inc = 1'b0;
  logic        irq, normal_sum, abnormal_sum;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_pulse(ev_pulse), .miss_inc(miss_inc), .crc_inc(crc_inc),
    .irq(irq), .normal_sum(normal_sum), .abnormal_sum(abnormal_sum)
  );

  // behavioural reference model
  int m_status = 0, m_enable = 0, m_rdata = 0;
  int m_cnt [2] = '{0, 0};

  always @(posedge clk) begin : mdl
    int ns, rv, c, near;
    int ofs [2];
    int incs [2];
    if (!rst_n) begin
      m_status <= 0; m_enable <= 0; m_rdata <= 0; m_cnt <= '{0, 0};
    end else begin
      ofs[0] = 'h7C; ofs[1] = 'h7E;
      incs[0] = miss_inc; incs[1] = crc_inc;
      rv = 0;
      if (reg_rd_en) begin
        if (reg_addr == 8'h0C)      rv = m_status;
        else if (reg_addr == 8'h0E) rv = m_enable;
        else if (reg_addr == 8'h7C) rv = m_cnt[0];
        else if (reg_addr == 8'h7E) rv = m_cnt[1];
      end
      m_rdata <= rv;
      near = 0;
      for (int k = 0; k < 2; k++) begin
        c = m_cnt[k];
        if (reg_rd_en && reg_addr == ofs[k]) c = incs[k];
        else if (incs[k] != 0 && c < 65535) c = c + 1;
        if (c == 49152 && m_cnt[k] != 49152) near = 1;
        m_cnt[k] <= c;
      end
      ns = m_status;
      if (reg_wr_en && reg_addr == 8'h0C) ns = ns & ~int'(reg_wdata);
      ns = ns | int'(ev_pulse) | (near << 7);
      m_status <= ns;
      if (reg_wr_en && reg_addr == 8'h0E) m_enable <= int'(reg_wdata);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock, after the edge settles
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R4 irq vs model", int'(irq), int'((m_status & m_enable) != 0));
      chk("R5 normal_sum vs model", int'(normal_sum), int'((m_status & 'h0003) != 0));
      chk("R5 abnormal_sum vs model", int'(abnormal_sum), int'((m_status & 'hC260) != 0));
      chk("R6 rdata vs model", int'(reg_rdata), m_rdata);
    end
  end

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    @(negedge clk); reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd_en = 1'b0;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] e);
    @(negedge clk); ev_pulse = e;
    @(negedge clk); ev_pulse = '0;
  endtask

  task automatic pump(input bit crc, input int n);
    @(negedge clk);
    if (crc) crc_inc = 1'b1; else miss_inc = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); crc_inc = 1'b0; miss_inc = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (R1..R10 incomplete) actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 irq during reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 sums", int'({normal_sum, abnormal_sum}), 0);
    chk("R1 rdata", int'(reg_rdata), 0);
    rd(8'h0C, 0, "R1 status");
    rd(8'h0E, 0, "R1 enable");
    rd(8'h7C, 0, "R1 miss count");
    rd(8'h7E, 0, "R1 crc count");

    // R2 sticky set, R4 masked
    pulse(16'h0001);
    rd(8'h0C, 'h0001, "R2 rx-done set");
    pulse(16'h8000);
    rd(8'h0C, 'h8001, "R2 wake-up set, sticky");
    chk("R4 irq masked by zero enable", int'(irq), 0);
    chk("R5 normal_sum", int'(normal_sum), 1);
    chk("R5 abnormal_sum", int'(abnormal_sum), 1);

    // R4 enable path
    wr(8'h0E, 16'h0001);
    rd(8'h0E, 'h0001, "R4 enable readback");
    chk("R4 irq asserted", int'(irq), 1);
    wr(8'h0E, 16'h0000);
    chk("R4 zero enable masks all", int'(irq), 0);

    // R3 write-one-to-clear
    wr(8'h0C, 16'h0001);
    rd(8'h0C, 'h8000, "R3 selective clear");
    chk("R5 normal_sum after clear", int'(normal_sum), 0);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 8'h0C; reg_wdata = 16'h8000; ev_pulse = 16'h8000;
    @(negedge clk);
    reg_wr_en = 1'b0; ev_pulse = '0;
    rd(8'h0C, 'h8000, "R3 event wins over clear");
    wr(8'h0C, 16'h8000);
    rd(8'h0C, 0, "R3 ack value read clears all");
    pulse(16'h0100);
    chk("R5 bit8 in neither group", int'({normal_sum, abnormal_sum}), 0);
    pulse(16'h0020);
    chk("R5 bit5 abnormal", int'(abnormal_sum), 1);
    wr(8'h0C, 16'hFFFF);

    // R6 unmapped and idle reads
    rd(8'h10, 0, "R6 unmapped offset");
    @(negedge clk);
    chk("R6 idle rdata", int'(reg_rdata), 0);

    // R7 counting, R8 read-clear
    pump(1'b1, 5);
    pump(1'b0, 3);
    rd(8'h7C, 3, "R7 miss count");
    rd(8'h7E, 5, "R7 crc count");
    rd(8'h7E, 0, "R8 crc cleared by read");
    @(negedge clk);
    crc_inc = 1'b1; reg_rd_en = 1'b1; reg_addr = 8'h7E;
    @(negedge clk);
    crc_inc = 1'b0; reg_rd_en = 1'b0;
    chk("R8 read value with coinciding inc", int'(reg_rdata), 0);
    rd(8'h7E, 1, "R8 coinciding inc survives");

    // R9 counter offsets are read-only
    pump(1'b0, 2);
    wr(8'h7C, 16'h1234);
    wr(8'h7E, 16'hFFFF);
    rd(8'h7C, 2, "R9 miss write ignored");
    rd(8'h7E, 0, "R9 crc write ignored");

    // R10 near-maximum on the missed-frame counter
    pump(1'b0, 49151);
    rd(8'h0C, 0, "R10 not yet at threshold");
    pump(1'b0, 1);
    rd(8'h0C, 'h0080, "R10 miss reaches threshold");
    wr(8'h0C, 16'h0080);
    pump(1'b0, 1);
    rd(8'h0C, 0, "R10 no re-trigger above threshold");
    rd(8'h7C, 'hC001, "R7 miss count above threshold");

    // R10 on the CRC-error counter
    pump(1'b1, 49152);
    rd(8'h0C, 'h0080, "R10 crc reaches threshold");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule